// File: doc/BRIEF.md
# External Bus Recovery Cycle Inserter

This block sits between the arbiter that picks the next external bus access and the sequencer that carries it out. It holds one recovery setting per chip-select channel, and it decides when the next access may start. When the direction of the bus turns around, the block inserts dead cycles: after a write followed by a read, and after a read followed by a write. The number of dead cycles comes from the setting of the channel that the finished access used.

An access request is offered on a valid/ready pair (`req_valid` / `req_ready`). The kind and the channel of the request are held steady while `req_valid` is high. The access is granted in any cycle where both are high. `req_ready` never depends on an earlier grant being taken. Back-pressure comes only from recovery still owed, or from an access still running. `req_stall` shows this back-pressure directly. The sequencer reports the end of a running access with a one-cycle `acc_done` pulse.

Idle cycles after that pulse count toward the recovery, so a quiet bus needs fewer dead cycles, or none. Each channel's settings are read and written through a plain 32-bit register port indexed by channel number.

Top module: `bus_recovery_gate`

## Requirements
- R1: After reset every setting field reads as zero, and the first request is ready at once because no access has completed yet.
- R2: A register write to channel c (0..6) stores wdata bits 27:24 as the post-write count and bits 19:16 as the post-read count. A read of channel c returns those fields in the same positions. All other read bits are 0, and `reg_rdata` follows `reg_addr` in the same cycle.
- R3: A register write to address 7 changes no setting, and a read of address 7 returns 0.
- R4: After a write access completes with `acc_done` in cycle c, a read request gets `req_ready` no earlier than cycle c+1+N. N is the post-write count of the channel of that write.
- R5: After a read access completes, a write request is delayed in the same way, using the post-read count of the read's channel.
- R6: When the next request has the same kind as the last completed access, no recovery is inserted.
- R7: Each cycle between `acc_done` and the request counts as an idle cycle and reduces the delay by one. The delay never goes below zero.
- R8: The count is taken from the channel of the finished access, also when the next request targets that same channel.
- R9: A register write made after `acc_done` does not change the delay of the pending request. It applies from the next completed access on.
- R10: From a grant until the matching `acc_done`, `req_ready` stays low.
- R11: `req_stall` is high exactly when `req_valid` is high and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Channel number of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_valid | input | 1 | Access request offered |
| req_write | input | 1 | Request kind: 1 write, 0 read |
| req_chan | input | 3 | Chip-select channel of the request |
| req_ready | output | 1 | Request may be granted this cycle |
| req_stall | output | 1 | Request held off |
| acc_done | input | 1 | One-cycle pulse at the end of the granted access |

## Verification
Register read data is combinational, so the bench checks it one cycle after the write edge, with the address still applied. `req_ready` is also combinational, on a counter that the `acc_done` edge clears. The bench drives every input at the falling edge and samples shortly after. It counts the stalled samples from the first cycle of the request up to the first ready sample. That count must equal the owed count minus the idle cycles the bench itself placed after the pulse, and never less than zero. The expected count uses a copy of the settings that the bench takes at the pulse, so register writes made later can be tested against R9.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_t;

  // recovery owed when the bus turns from one kind to the other
  function automatic logic [3:0] owed_cycles(
    input logic       have_hist,
    input acc_kind_t  last_kind,
    input acc_kind_t  next_kind,
    input logic [3:0] after_wr,
    input logic [3:0] after_rd
  );
    if (!have_hist || last_kind == next_kind) return 4'd0;
    return (last_kind == ACC_WRITE) ? after_wr : after_rd;
  endfunction
endpackage

// File: rtl/brc_settings.sv
module brc_settings #(
  parameter int NUM_CH = 7,
  parameter int DW     = 32,
  parameter int FW     = 4,
  parameter int WR_LSB = 24,
  parameter int RD_LSB = 16,
  parameter int AW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [AW-1:0] sel_ch,
  output logic [FW-1:0] sel_wr,
  output logic [FW-1:0] sel_rd
);
  localparam logic [DW-1:0] FIELD_MASK =
    ({{(DW-FW){1'b0}}, {FW{1'b1}}} << WR_LSB) |
    ({{(DW-FW){1'b0}}, {FW{1'b1}}} << RD_LSB);

  logic [FW-1:0] wr_q [NUM_CH];
  logic [FW-1:0] rd_q [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wr_q[ch] <= '0;
        rd_q[ch] <= '0;
      end else if (reg_we && reg_addr == AW'(ch)) begin
        wr_q[ch] <= reg_wdata[WR_LSB +: FW];
        rd_q[ch] <= reg_wdata[RD_LSB +: FW];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    sel_wr    = '0;
    sel_rd    = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == AW'(i)) begin
        reg_rdata[WR_LSB +: FW] = wr_q[i];
        reg_rdata[RD_LSB +: FW] = rd_q[i];
      end
      if (sel_ch == AW'(i)) begin
        sel_wr = wr_q[i];
        sel_rd = rd_q[i];
      end
    end
  end

  // R2: reserved bits never read back as ones
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~FIELD_MASK) == '0);
  // R3: an address with no channel reads as zero
  a_r3_bad_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) >= NUM_CH) |-> reg_rdata == '0);
endmodule

// File: rtl/brc_tracker.sv
module brc_tracker
  import brc_pkg::*;
#(
  parameter int FW = 4,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant,
  input  logic          req_write,
  input  logic [AW-1:0] req_chan,
  input  logic          acc_done,
  input  logic [FW-1:0] sel_wr,
  input  logic [FW-1:0] sel_rd,
  output logic [AW-1:0] last_chan,
  output acc_kind_t     last_kind,
  output logic          busy,
  output logic          have_hist,
  output logic [FW-1:0] snap_wr,
  output logic [FW-1:0] snap_rd
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      have_hist <= 1'b0;
      last_chan <= '0;
      last_kind <= ACC_READ;
      snap_wr   <= '0;
      snap_rd   <= '0;
    end else if (grant) begin
      busy      <= 1'b1;
      last_chan <= req_chan;
      last_kind <= req_write ? ACC_WRITE : ACC_READ;
    end else if (busy && acc_done) begin
      busy      <= 1'b0;
      have_hist <= 1'b1;
      snap_wr   <= sel_wr;   // settings frozen at completion (R9)
      snap_rd   <= sel_rd;
    end
  end

  // R10: completion releases the bus in the next cycle
  a_r10_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc_done) |=> !busy);
  // R10: a grant always starts a busy period
  a_r10_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> busy);
endmodule

// File: rtl/brc_gate.sv
module brc_gate
  import brc_pkg::*;
#(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          have_hist,
  input  acc_kind_t     last_kind,
  input  logic [FW-1:0] snap_wr,
  input  logic [FW-1:0] snap_rd,
  input  logic          acc_done,
  input  logic          req_valid,
  input  logic          req_write,
  output logic          req_ready,
  output logic          req_stall,
  output logic          grant
);
  localparam logic [FW-1:0] IDLE_MAX = '1;

  logic [FW-1:0] idle_q;
  logic [FW-1:0] need;

  always_ff @(posedge clk) begin
    if (!rst_n)                 idle_q <= '0;
    else if (busy && acc_done)  idle_q <= '0;
    else if (!busy && idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
  end

  always_comb begin
    need      = owed_cycles(have_hist, last_kind,
                            req_write ? ACC_WRITE : ACC_READ, snap_wr, snap_rd);
    req_ready = !busy && (idle_q >= need);
    req_stall = req_valid && !req_ready;
    grant     = req_valid && req_ready;
  end

  // R10: nothing is granted while an access runs
  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R6: a request of the same kind as the last access is never held off
  a_r6_same_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && have_hist && (req_write == (last_kind == ACC_WRITE)))
      |-> req_ready);
  // R1: before any completed access no recovery is owed
  a_r1_no_history: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !have_hist) |-> req_ready);
endmodule

// File: rtl/bus_recovery_gate.sv
module bus_recovery_gate
  import brc_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int DW     = 32,
  parameter int FW     = 4,
  parameter int WR_LSB = 24,
  parameter int RD_LSB = 16,
  parameter int AW     = $clog2(NUM_CH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_chan,
  output logic          req_ready,
  output logic          req_stall,
  input  logic          acc_done
);
  logic          grant, busy, have_hist;
  logic [AW-1:0] last_chan;
  acc_kind_t     last_kind;
  logic [FW-1:0] sel_wr, sel_rd, snap_wr, snap_rd;

  brc_settings #(
    .NUM_CH(NUM_CH), .DW(DW), .FW(FW),
    .WR_LSB(WR_LSB), .RD_LSB(RD_LSB), .AW(AW)
  ) u_settings (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sel_ch(last_chan), .sel_wr(sel_wr), .sel_rd(sel_rd)
  );

  brc_tracker #(.FW(FW), .AW(AW)) u_tracker (
    .clk(clk), .rst_n(rst_n), .grant(grant), .req_write(req_write),
    .req_chan(req_chan), .acc_done(acc_done), .sel_wr(sel_wr),
    .sel_rd(sel_rd), .last_chan(last_chan), .last_kind(last_kind),
    .busy(busy), .have_hist(have_hist), .snap_wr(snap_wr), .snap_rd(snap_rd)
  );

  brc_gate #(.FW(FW)) u_gate (
    .clk(clk), .rst_n(rst_n), .busy(busy), .have_hist(have_hist),
    .last_kind(last_kind), .snap_wr(snap_wr), .snap_rd(snap_rd),
    .acc_done(acc_done), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .req_stall(req_stall), .grant(grant)
  );

  // R11: stall and ready never claim the same request
  a_r11_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_stall && req_ready));
endmodule

// File: tb/test_bus_recovery_gate.sv
module test_bus_recovery_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FMASK = 32'h0F0F_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_chan = '0;
  logic        req_ready, req_stall;
  logic        acc_done = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done_flag = 0;

  logic [31:0] mdl [7];
  bit   have_hist = 0;
  bit   last_w = 0;
  int   snap_w = 0, snap_r = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_recovery_gate i_bus_recovery_gate (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_write(req_write), .req_chan(req_chan), .req_ready(req_ready),
    .req_stall(req_stall), .acc_done(acc_done)
  );

  function automatic int exp_wait(bit hist, bit lw, bit nw, int sw, int sr, int gap);
    int n;
    if (!hist || lw == nw) n = 0;
    else n = lw ? sw : sr;
    return (n > gap) ? n - gap : 0;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic maybe_reg_write();
    if ($urandom_range(0, 3) == 0) begin
      int a = $urandom_range(0, 7);
      logic [31:0] d = $urandom;
      reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
      if (a < 7) mdl[a] = d & FMASK;
    end else reg_we = 1'b0;
  endtask

  task automatic do_access(bit w, int ch, int gap, string tag);
    int waited = 0;
    int expw;
    for (int i = 0; i < gap; i++) begin
      maybe_reg_write();
      @(negedge clk);
    end
    reg_we = 1'b0;
    req_valid = 1'b1; req_write = w; req_chan = 3'(ch);
    expw = exp_wait(have_hist, last_w, w, snap_w, snap_r, gap);
    forever begin
      #1;
      check(req_stall == (req_valid && !req_ready), "R11 stall", req_stall, !req_ready);
      if (req_ready) break;
      waited++;
      if (waited > 40) break;
      maybe_reg_write();   // R9: later writes must not shorten or lengthen
      @(negedge clk);
    end
    check(waited == expw, tag, waited, expw);
    @(negedge clk);
    reg_we = 1'b0;
    for (int b = 0; b < $urandom_range(0, 2); b++) begin
      req_valid = 1'b1; req_write = $urandom_range(0, 1);
      #1;
      check(!req_ready, "R10 busy", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    #1;
    check(!req_ready, "R10 busy before done", req_ready, 0);
    acc_done = 1'b1;
    have_hist = 1; last_w = w;
    snap_w = int'(mdl[ch][27:24]); snap_r = int'(mdl[ch][19:16]);
    @(negedge clk);
    acc_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0101));
    for (int i = 0; i < 7; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 7; i++) begin
      reg_addr = 3'(i); #1;
      check(reg_rdata == 0, "R1 reset field", reg_rdata, 0);
    end
    req_valid = 1'b1; req_write = 1'b0; #1;
    check(req_ready, "R1 first ready", req_ready, 1);
    req_valid = 1'b0;
    // R2: field placement and reserved bits
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk); reg_we = 1'b0; #1;
    check(reg_rdata == 32'h0F0F_0000, "R2 readback", reg_rdata, 32'h0F0F_0000);
    mdl[3] = 32'h0F0F_0000;
    reg_addr = 3'd2; #1;
    check(reg_rdata == 0, "R2 other channel", reg_rdata, 0);
    // R3: address 7 ignored
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd7; reg_wdata = 32'h0A0B_0000;
    @(negedge clk); reg_we = 1'b0; #1;
    check(reg_rdata == 0, "R3 addr7 read", reg_rdata, 0);
    for (int i = 0; i < 7; i++) begin
      reg_addr = 3'(i); #1;
      check(reg_rdata == mdl[i], "R3 no side effect", reg_rdata, mdl[i]);
    end
    // directed: write ch3 (15), read same ch3, no gap (R4, R8)
    reg_addr = 3'd5; reg_wdata = 32'h0300_0200; reg_we = 1'b1; mdl[5] = 32'h0300_0200;
    @(negedge clk); reg_we = 1'b0;
    do_access(1, 3, 0, "R1 first access");
    do_access(0, 3, 0, "R4 R8 write->read full");
    do_access(1, 5, 0, "R5 read->write");
    do_access(1, 5, 0, "R6 write->write");
    do_access(0, 2, 1, "R7 idle reduces");
    do_access(1, 2, 20, "R7 idle covers");
    // random mix
    for (int t = 0; t < 400; t++) begin
      int g = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 17) : $urandom_range(0, 3);
      do_access($urandom_range(0, 1), $urandom_range(0, 6), g, "R4 R5 R7 R9 random");
    end
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule